// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD bytes. The fields are seconds, minutes, hours, day of week, day of month, month, two-digit year and a century flag. A single-cycle enable pulse, issued once per second, advances the seconds. Each field that wraps carries into the next field on the same clock edge, so a tick at 23:59:59 on the last day of a year changes every field at once.

Software sets any field through a write port made of an address, a byte and a strobe. It reads the fields back through a combinational read port. The hours byte holds its own 12/24-hour mode flag. In 12-hour mode the same byte also holds a PM flag. The counter handles month lengths and leap years.

Invalid values written by software give undefined counting and are not corrected. Changing the mode flag only stores the byte that was written; the hours are not converted.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01 with century 0, and year 0x00.
- R2: Seconds and minutes count in BCD from 00 to 59. A tick when a field reads 59 sets it to 00 and advances the next field on the same edge.
- R3: When hours bit 6 is 0 (24-hour mode), bits 5:0 hold the hour 00..23 in BCD, with bit 5 as the upper tens bit. On a carry, 23 wraps to 00 and advances the day.
- R4: When hours bit 6 is 1 (12-hour mode), bits 4:0 hold 12, 01..11 in BCD and bit 5 is PM. The step 11 to 12 flips bit 5. The step 11 PM to 12 AM advances the day.
- R5: The day of week advances on each day advance and wraps from 7 to 1.
- R6: On a day advance the date wraps to 01 after its last day, and the month then advances. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For February it is 29 when the binary value of the year is divisible by 4, and 28 otherwise.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and toggles the century flag, which is bit 7 of the month byte.
- R8: Without a tick and without a write, no field changes.
- R9: A write (wr_en=1) loads the addressed field on that edge and overrides any tick increment of that field. Carries into other fields are still taken from the values held before the edge. Addresses: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year.
- R10: These bits always read 0: bit 7 of seconds, minutes and hours; bits 7:3 of day of week; bits 7:6 of date; bits 6:5 of month. Address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second that advances the time |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Field selected for the write |
| wr_data | input | 8 | Packed BCD byte to store |
| rd_addr | input | 3 | Field selected for reading |
| rd_data | output | 8 | Packed BCD byte of the selected field |

## Verification
The bench sweeps all 24 hour states in both hour modes across the 59:59 boundary. A design that flips PM at the wrong hour, or starts a new day at 12 PM instead of 12 AM, fails there. Every month is crossed at its last day in a leap year and in an ordinary year, and the February rollover is checked for all 100 years. This exposes a fixed 31-day month, or a leap test that reads the BCD byte as binary. The bench also crosses year 99 twice to show the century flag toggles rather than sets. It drives a write in the same cycle as a tick to show that the write wins on its own field while the carry into the next field still happens.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6
    } field_e;

    // Increment a two-digit BCD byte by one (no upper wrap handling).
    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        logic [3:0] lo_d;
        logic [3:0] hi_d;
        lo_d = v[3:0];
        hi_d = v[7:4];
        if (lo_d == 4'd9) begin
            return {hi_d + 4'd1, 4'd0};
        end
        return {hi_d, lo_d + 4'd1};
    endfunction

    // Year (BCD) divisible by 4: 10*t + u = 2*t + u (mod 4).
    function automatic logic leap_year(input logic [BYTE_W-1:0] y);
        logic [4:0] s;
        s = {3'b000, y[4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last day of month, BCD in and out.
    function automatic logic [BYTE_W-1:0] last_day(input logic [BYTE_W-1:0] m,
                                                   input logic [BYTE_W-1:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_field.sv
module bcd_field #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] val,
    output logic         carry
);
    import bcd_calendar_pkg::*;

    assign carry = inc && (val == hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= RST_VAL;
        end else if (ld) begin
            val <= ld_val;
        end else if (inc) begin
            val <= (val == hi) ? lo : bcd_inc(val);
        end
    end

    a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
        ld |=> (val == $past(ld_val)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld && !inc) |=> $stable(val));

    a_r2_wrap_to_low: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && (val == hi)) |=> (val == $past(lo)));

endmodule

// File: rtl/bcd_hour_unit.sv
module bcd_hour_unit (
    input  logic       clk,
    input  logic       rst,
    input  logic       inc,
    input  logic       ld,
    input  logic [6:0] ld_val,
    output logic [6:0] hour,
    output logic       day_carry
);
    import bcd_calendar_pkg::*;

    logic       mode12;
    logic       pm;
    logic [7:0] inc12;
    logic [7:0] inc24;
    logic [6:0] nxt;

    assign mode12 = hour[6];
    assign pm     = hour[5];
    assign inc12  = bcd_inc({3'b000, hour[4:0]});
    assign inc24  = bcd_inc({2'b00, hour[5:0]});

    always_comb begin
        if (mode12) begin
            if (hour[4:0] == 5'h12) begin
                nxt = {1'b1, pm, 5'h01};
            end else if (hour[4:0] == 5'h11) begin
                nxt = {1'b1, ~pm, 5'h12};
            end else begin
                nxt = {1'b1, pm, inc12[4:0]};
            end
        end else begin
            if (hour[5:0] == 6'h23) begin
                nxt = 7'h00;
            end else begin
                nxt = {1'b0, inc24[5:0]};
            end
        end
    end

    assign day_carry = inc && (mode12 ? (pm && hour[4:0] == 5'h11)
                                      : (hour[5:0] == 6'h23));

    always_ff @(posedge clk) begin
        if (rst) begin
            hour <= 7'h00;
        end else if (ld) begin
            hour <= ld_val;
        end else if (inc) begin
            hour <= nxt;
        end
    end

    a_r9_hour_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> (hour == $past(ld_val)));

    a_r3_midnight_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && !hour[6] && hour[5:0] == 6'h23) |=> (hour == 7'h00));

    a_r4_pm_flip_at_eleven: assert property (@(posedge clk) disable iff (rst)
        (!$stable(hour[5]) && hour[6] && $past(hour[6]) && !$past(ld))
            |-> ($past(hour[4:0]) == 5'h11));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_calendar_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int N_SM = 2;   // seconds and minutes share one structure

    logic [DW-1:0] sm_val [N_SM];
    logic [N_SM:0] sm_carry;

    assign sm_carry[0] = tick;

    for (genvar g = 0; g < N_SM; g++) begin : g_sm
        localparam logic [AW-1:0] ADR = AW'(g);
        logic sel;
        assign sel = wr_en && (wr_addr == ADR);
        bcd_field #(.W(DW), .RST_VAL(8'h00)) u_fld (
            .clk    (clk),
            .rst    (rst),
            .inc    (sm_carry[g]),
            .ld     (sel),
            .ld_val ({1'b0, wr_data[6:0]}),
            .lo     (8'h00),
            .hi     (8'h59),
            .val    (sm_val[g]),
            .carry  (sm_carry[g+1])
        );
    end

    logic [6:0] hour_q;
    logic       day_inc;

    bcd_hour_unit u_hour (
        .clk       (clk),
        .rst       (rst),
        .inc       (sm_carry[N_SM]),
        .ld        (wr_en && wr_addr == FLD_HOUR),
        .ld_val    (wr_data[6:0]),
        .hour      (hour_q),
        .day_carry (day_inc)
    );

    logic [DW-1:0] dow_q, date_q, mon_q, year_q, date_hi;
    logic          dow_wrap, mon_inc, year_inc, year_wrap;
    logic          cent_q;
    logic          mon_ld;

    assign mon_ld = wr_en && (wr_addr == FLD_MONTH);

    bcd_field #(.W(DW), .RST_VAL(8'h01)) u_dow (
        .clk (clk), .rst (rst), .inc (day_inc),
        .ld (wr_en && wr_addr == FLD_DOW), .ld_val ({5'b0, wr_data[2:0]}),
        .lo (8'h01), .hi (8'h07), .val (dow_q), .carry (dow_wrap)
    );

    assign date_hi = last_day(mon_q, year_q);

    bcd_field #(.W(DW), .RST_VAL(8'h01)) u_date (
        .clk (clk), .rst (rst), .inc (day_inc),
        .ld (wr_en && wr_addr == FLD_DATE), .ld_val ({2'b0, wr_data[5:0]}),
        .lo (8'h01), .hi (date_hi), .val (date_q), .carry (mon_inc)
    );

    bcd_field #(.W(DW), .RST_VAL(8'h01)) u_month (
        .clk (clk), .rst (rst), .inc (mon_inc),
        .ld (mon_ld), .ld_val ({3'b0, wr_data[4:0]}),
        .lo (8'h01), .hi (8'h12), .val (mon_q), .carry (year_inc)
    );

    bcd_field #(.W(DW), .RST_VAL(8'h00)) u_year (
        .clk (clk), .rst (rst), .inc (year_inc),
        .ld (wr_en && wr_addr == FLD_YEAR), .ld_val (wr_data),
        .lo (8'h00), .hi (8'h99), .val (year_q), .carry (year_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cent_q <= 1'b0;
        end else if (mon_ld) begin
            cent_q <= wr_data[7];
        end else if (year_wrap) begin
            cent_q <= ~cent_q;
        end
    end

    always_comb begin
        case (rd_addr)
            FLD_SEC:   rd_data = sm_val[0];
            FLD_MIN:   rd_data = sm_val[1];
            FLD_HOUR:  rd_data = {1'b0, hour_q};
            FLD_DOW:   rd_data = dow_q;
            FLD_DATE:  rd_data = date_q;
            FLD_MONTH: rd_data = {cent_q, 2'b00, mon_q[4:0]};
            FLD_YEAR:  rd_data = year_q;
            default:   rd_data = '0;
        endcase
    end

    a_r7_century_source: assert property (@(posedge clk) disable iff (rst)
        !$stable(cent_q) |-> ($past(year_wrap) || $past(mon_ld)));

    a_r5_dow_wrap_to_one: assert property (@(posedge clk) disable iff (rst)
        (dow_wrap && !(wr_en && wr_addr == FLD_DOW)) |=> (dow_q == 8'h01));

    a_r6_date_wrap_to_one: assert property (@(posedge clk) disable iff (rst)
        (mon_inc && !(wr_en && wr_addr == FLD_DATE)) |=> (date_q == 8'h01));

endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bcd_calendar i_bcd_calendar (
        .clk (clk), .rst (rst), .tick (tick), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data), .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_addr = 3'(a);
        #1;
        v = rd_data;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic end_of_day(input logic [7:0] h);
        wr(2, h); wr(1, 8'h59); wr(0, 8'h59);
    endtask

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R10 unused address
        begin
            logic [7:0] exp_r [8] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
            for (int a = 0; a < 8; a++) begin
                rd(a, v);
                chk((a == 7) ? "R10 addr7" : "R1 reset", v, exp_r[a]);
            end
        end

        // R8 hold without tick
        repeat (5) @(negedge clk);
        rd(0, v); chk("R8 hold sec", v, 8'h00);

        // R2 seconds sweep and carry into minutes
        wr(1, 8'h07);
        for (int s = 1; s <= 60; s++) begin
            pulse;
            rd(0, v); chk("R2 sec", v, bcd(s % 60));
        end
        rd(1, v); chk("R2 min carry", v, 8'h08);
        wr(1, 8'h59); wr(0, 8'h59); wr(2, 8'h05);
        pulse;
        rd(1, v); chk("R2 min wrap", v, 8'h00);
        rd(2, v); chk("R2 hour carry", v, 8'h06);

        // R3 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            wr(3, 8'h01);
            end_of_day(bcd(h));
            pulse;
            rd(2, v); chk("R3 hour24", v, bcd((h + 1) % 24));
            rd(3, v); chk("R3 day advance", v, (h == 23) ? 8'h02 : 8'h01);
        end

        // R4 12-hour sweep, k=0 is 12 AM
        for (int k = 0; k < 24; k++) begin
            int h12, n12;
            logic pm, npm;
            h12 = (k % 12 == 0) ? 12 : k % 12;
            pm  = (k >= 12);
            n12 = ((k + 1) % 12 == 0) ? 12 : (k + 1) % 12;
            npm = (((k + 1) % 24) >= 12);
            wr(3, 8'h01);
            end_of_day({1'b0, 1'b1, pm, bcd(h12)[4:0]});
            pulse;
            rd(2, v); chk("R4 hour12", v, {1'b0, 1'b1, npm, bcd(n12)[4:0]});
            rd(3, v); chk("R4 day advance", v, (k == 23) ? 8'h02 : 8'h01);
        end

        // R5 day-of-week sweep
        for (int d = 1; d <= 7; d++) begin
            wr(3, bcd(d));
            end_of_day(8'h23);
            pulse;
            rd(3, v); chk("R5 dow", v, bcd((d == 7) ? 1 : d + 1));
        end

        // R6 month lengths in an ordinary and a leap year
        for (int yi = 0; yi < 2; yi++) begin
            int y;
            y = (yi == 0) ? 23 : 24;
            for (int m = 1; m <= 12; m++) begin
                int last;
                last = mdays(m, y);
                wr(6, bcd(y)); wr(5, bcd(m)); wr(4, bcd(last - 1));
                end_of_day(8'h23);
                pulse;
                rd(4, v); chk("R6 day before last", v, bcd(last));
                rd(5, v); chk("R6 month held", v, bcd(m));
                end_of_day(8'h23);
                pulse;
                rd(4, v); chk("R6 date wrap", v, 8'h01);
                rd(5, v); chk("R6 month advance", v, bcd((m == 12) ? 1 : m + 1));
                rd(6, v); chk("R7 year", v, bcd((m == 12) ? y + 1 : y));
            end
        end

        // R6 February 28 across all years
        for (int y = 0; y < 100; y++) begin
            wr(6, bcd(y)); wr(5, 8'h02); wr(4, 8'h28);
            end_of_day(8'h23);
            pulse;
            rd(4, v); chk("R6 feb leap", v, (y % 4 == 0) ? 8'h29 : 8'h01);
        end

        // R7 century toggles on both crossings
        wr(6, 8'h99); wr(5, 8'h12); wr(4, 8'h31);
        end_of_day(8'h23);
        pulse;
        rd(5, v); chk("R7 century set", v, 8'h81);
        rd(6, v); chk("R7 year wrap", v, 8'h00);
        wr(6, 8'h99); wr(5, 8'h92); wr(4, 8'h31);
        end_of_day(8'h23);
        pulse;
        rd(5, v); chk("R7 century clear", v, 8'h01);

        // R9 write beats tick on its own field
        wr(2, 8'h10); wr(1, 8'h20); wr(0, 8'h30);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h45;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(0, v); chk("R9 sec write wins", v, 8'h45);
        rd(1, v); chk("R9 min untouched", v, 8'h20);
        wr(0, 8'h59);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(1, v); chk("R9 min write wins", v, 8'h33);
        rd(0, v); chk("R9 sec still wraps", v, 8'h00);
        rd(2, v); chk("R9 hour no carry", v, 8'h10);
        // mode bit change stores byte as written
        wr(2, 8'h55);
        rd(2, v); chk("R9 hour stored raw", v, 8'h55);

        // R10 masked bits
        wr(0, 8'hFF); rd(0, v); chk("R10 sec bit7", v, 8'h7F);
        wr(3, 8'hFF); rd(3, v); chk("R10 dow bits", v, 8'h07);
        wr(4, 8'hFF); rd(4, v); chk("R10 date bits", v, 8'h3F);
        wr(5, 8'h7F); rd(5, v); chk("R10 month bits", v, 8'h1F);
        wr(2, 8'hFF); rd(2, v); chk("R10 hour bit7", v, 8'h7F);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule